// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a paired transmitter and receiver for asynchronous serial lines. A processor programs a 6-bit frame mode word, pushes bytes through an 8-bit transmit write port, pulls received bytes from an 8-bit read port, and polls an 8-bit status word. Bit timing comes from an external strobe, `tick16`, which pulses for one clock cycle at sixteen times the bit rate. All frame timing is counted in these strobes. Stop time of one and a half bits is therefore an exact count of 24 strobes.

The transmitter has a single holding register in front of a shift register. Its state machine walks `TX_IDLE -> TX_START -> TX_DATA -> (TX_PARITY) -> TX_STOP`. From `TX_STOP` it goes back to `TX_START` when another byte is already waiting, and to `TX_IDLE` when none is.

The receiver passes the line through a two-flop synchronizer and walks `RX_IDLE -> RX_START -> RX_DATA -> (RX_PARITY) -> RX_STOP -> RX_IDLE`. A low seen in `RX_IDLE` moves it to `RX_START`. The start bit is confirmed by the eighth strobe sample. If the line has gone high again by then, the receiver takes the `RX_START -> RX_IDLE` abort path. Once a character is complete, it lands in the receive data register and updates the sticky error flags.

Top module: `serial_xcvr`

Mode word fields:
- bits [1:0]: character length, equal to 5 plus the field value.
- bit 2: parity enable.
- bit 3: parity sense, where 1 selects odd.
- bits [5:4]: stop time. 0 gives 16 strobes, 1 gives 24, and 2 or 3 give 32.

After reset the mode is 8 data bits, no parity, one stop bit (value 6'h03).

## Requirements
- R1: After reset `txd` is 1, `status` equals 8'h05 and `rx_rdata` is 0.
- R2: A transmitted character is one low start bit, then the data bits LSB first, then an optional parity bit, then high stop time. Each bit lasts 16 strobes. The data length is 5 plus mode[1:0].
- R3: When mode[2] is 1, a parity bit follows the data. With mode[3]=0 it makes the count of ones in the data and parity even. With mode[3]=1 it makes that count odd.
- R4: When a second byte is already waiting, its start bit begins exactly (1 + length + parity) * 16 + S strobes after the previous start bit. S is 16, 24 or 32 for mode[5:4] = 0, 1, or 2 and 3.
- R5: status[0] (transmitter ready) is 1 exactly when the holding register is empty. A transmit write while it is 0 is ignored.
- R6: status[2] (transmitter empty) is 1 only when both the holding register and the shift register are empty and the line is idle.
- R7: The receiver confirms a start bit at the eighth strobe after the falling edge. A low pulse shorter than that produces no character.
- R8: status[1] (receiver ready) rises when a character completes and falls after an `rx_re` pulse. A character shorter than 8 bits reads back with its upper bits zero.
- R9: A parity mismatch on a received character sets status[3]. The bit stays set until an `stat_re` pulse clears it.
- R10: A low level at the first stop sample sets status[5]. The bit stays set until an `stat_re` pulse clears it.
- R11: A character that completes while status[1] is still set overwrites the held byte and sets status[4]. An `stat_re` pulse clears status[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word value |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_re | input | 1 | Receive data read strobe, clears receiver ready |
| rx_rdata | output | 8 | Last received character |
| stat_re | input | 1 | Status read strobe, clears the three error bits |
| status | output | 8 | {2'b0, frame err, overrun, parity err, tx empty, rx ready, tx ready} |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |

## Verification
The main path runs as a loopback across six frame modes. Together they cover every data length, all three parity settings and all three stop times. Each mode sends a byte and its complement back to back. The serial pattern checks bit order and parity sense. The spacing between the two start edges separates the three stop counts. The all-ones byte sent with a 5-bit length shows that the upper bits are cleared.

Directed frames driven from the bench cover the remaining cases:
- a bad stop level (framing error);
- a wrong parity bit;
- two unread characters (overrun);
- a short glitch. This shows that a rejected start differs from an accepted one.

A write into a full holding register is shown to leave the transmitted data unchanged.

// File: rtl/sx_pkg.sv
`timescale 1ns/1ps
package sx_pkg;
    localparam int SX_MODE_W = 6;

    typedef struct packed {
        logic [1:0] stop;
        logic       par_odd;
        logic       par_en;
        logic [1:0] len;
    } sx_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction
endpackage

// File: rtl/sx_tx.sv
`timescale 1ns/1ps
module sx_tx
    import sx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  sx_cfg_t       cfg,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic          txd,
    output logic          tx_ready,
    output logic          tx_empty
);
    localparam int CW = $clog2(2 * OSR);

    tx_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [2:0]     bit_idx;
    logic [7:0]     shreg;
    logic           par_q;
    logic [7:0]     thr_q;
    logic           thr_full;
    logic           load;
    logic           bit_end;
    logic [2:0]     last_idx;
    logic [CW-1:0]  stop_last;
    logic           par_calc;

    assign bit_end  = tick && (cnt == CW'(OSR - 1));
    assign last_idx = 3'd4 + {1'b0, cfg.len};
    assign par_calc = (^(thr_q & len_mask(cfg.len))) ^ cfg.par_odd;

    always_comb begin
        unique case (cfg.stop)
            2'd0:    stop_last = CW'(OSR - 1);
            2'd1:    stop_last = CW'(OSR + OSR / 2 - 1);
            default: stop_last = CW'(2 * OSR - 1);
        endcase
    end

    // next state
    always_comb begin
        state_n = state;
        load    = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (tick && thr_full) begin
                    state_n = TX_START;
                    load    = 1'b1;
                end
            end
            TX_START: begin
                if (bit_end) state_n = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end && bit_idx == last_idx)
                    state_n = cfg.par_en ? TX_PARITY : TX_STOP;
            end
            TX_PARITY: begin
                if (bit_end) state_n = TX_STOP;
            end
            TX_STOP: begin
                if (tick && cnt == stop_last) begin
                    if (thr_full) begin
                        state_n = TX_START;
                        load    = 1'b1;
                    end else begin
                        state_n = TX_IDLE;
                    end
                end
            end
            default: state_n = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
            thr_q    <= '0;
            thr_full <= 1'b0;
        end else begin
            if (load) begin
                shreg <= thr_q;
                par_q <= par_calc;
            end else if (state == TX_DATA && bit_end) begin
                shreg <= {1'b0, shreg[7:1]};
            end

            if (tick) begin
                if (state == TX_IDLE || state_n != state ||
                    (state != TX_STOP && cnt == CW'(OSR - 1)))
                    cnt <= '0;
                else
                    cnt <= cnt + CW'(1);
            end

            if (state != TX_DATA)  bit_idx <= '0;
            else if (bit_end)      bit_idx <= bit_idx + 3'd1;

            if (load) thr_full <= 1'b0;
            if (wr && !thr_full) begin
                thr_q    <= wdata;
                thr_full <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
        tx_ready = !thr_full;
        tx_empty = !thr_full && (state == TX_IDLE);
    end
endmodule

// File: rtl/sx_rx.sv
`timescale 1ns/1ps
module sx_rx
    import sx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam int CW = $clog2(OSR);

    rx_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [2:0]     bit_idx;
    logic [7:0]     shreg;
    logic           par_q;
    logic           sync1, rxs;
    logic           sample;
    logic           start_chk;
    logic [2:0]     last_idx;
    logic [7:0]     aligned;

    assign sample    = tick && (cnt == CW'(OSR - 1));
    assign start_chk = tick && (cnt == CW'(OSR / 2 - 2));
    assign last_idx  = 3'd4 + {1'b0, len};
    assign aligned   = shreg >> (2'd3 - len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rxs   <= 1'b1;
        end else begin
            sync1 <= rxd;
            rxs   <= sync1;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxs) state_n = RX_START;
            RX_START:  if (start_chk) state_n = rxs ? RX_IDLE : RX_DATA;
            RX_DATA: begin
                if (sample && bit_idx == last_idx)
                    state_n = par_en ? RX_PARITY : RX_STOP;
            end
            RX_PARITY: if (sample) state_n = RX_STOP;
            RX_STOP:   if (sample) state_n = RX_IDLE;
            default:   state_n = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // datapath and delivery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            if (tick) begin
                if (state == RX_IDLE || state_n != state || cnt == CW'(OSR - 1))
                    cnt <= '0;
                else
                    cnt <= cnt + CW'(1);
            end

            if (state != RX_DATA) bit_idx <= '0;
            else if (sample)      bit_idx <= bit_idx + 3'd1;

            if (state == RX_DATA && sample)   shreg <= {rxs, shreg[7:1]};
            if (state == RX_PARITY && sample) par_q <= rxs;

            done <= (state == RX_STOP) && sample;
            if (state == RX_STOP && sample) begin
                data <= aligned;
                perr <= par_en && ((^aligned) ^ par_q ^ par_odd);
                ferr <= !rxs;
            end
        end
    end
endmodule

// File: rtl/sx_flags.sv
`timescale 1ns/1ps
module sx_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_done,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_re,
    input  logic       stat_re,
    output logic       rx_ready,
    output logic [7:0] rbr,
    output logic       perr,
    output logic       ferr,
    output logic       oerr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
            rbr      <= '0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
            oerr     <= 1'b0;
        end else begin
            if (rx_done) begin
                rbr      <= rx_data;
                rx_ready <= 1'b1;
            end else if (rx_re) begin
                rx_ready <= 1'b0;
            end
            perr <= (perr && !stat_re) || (rx_done && rx_perr);
            ferr <= (ferr && !stat_re) || (rx_done && rx_ferr);
            oerr <= (oerr && !stat_re) || (rx_done && rx_ready && !rx_re);
        end
    end
endmodule

// File: rtl/serial_xcvr.sv
`timescale 1ns/1ps
module serial_xcvr
    import sx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 mode_we,
    input  logic [SX_MODE_W-1:0] mode_wdata,
    input  logic                 tx_we,
    input  logic [7:0]           tx_wdata,
    input  logic                 rx_re,
    output logic [7:0]           rx_rdata,
    input  logic                 stat_re,
    output logic [7:0]           status,
    output logic                 txd,
    input  logic                 rxd
);
    sx_cfg_t    cfg;
    logic       tx_ready, tx_empty;
    logic       rx_done;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr;
    logic       rx_ready, perr, ferr, oerr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cfg <= sx_cfg_t'(SX_MODE_W'(6'h03));
        else if (mode_we) cfg <= sx_cfg_t'(mode_wdata);
    end

    sx_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .cfg(cfg),
        .wr(tx_we), .wdata(tx_wdata),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    sx_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .len(cfg.len), .par_en(cfg.par_en), .par_odd(cfg.par_odd),
        .rxd(rxd), .done(rx_done), .data(rx_data),
        .perr(rx_perr), .ferr(rx_ferr)
    );

    sx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_re(rx_re), .stat_re(stat_re),
        .rx_ready(rx_ready), .rbr(rx_rdata), .perr(perr), .ferr(ferr), .oerr(oerr)
    );

    assign status = {2'b00, ferr, oerr, perr, tx_empty, rx_ready, tx_ready};
endmodule

// File: rtl/sx_checker.sv
`timescale 1ns/1ps
module sx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_we,
    input logic       rx_re,
    input logic       stat_re,
    input logic       txd,
    input logic [7:0] status,
    input logic       rx_done,
    input logic [7:0] thr_q
);
    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> txd);

    assert_empty_means_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[0]);

    assert_full_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && !status[0]) |=> $stable(thr_q));

    assert_done_sets_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> status[1]);

    assert_read_clears_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_re && !rx_done) |=> !status[1]);

    assert_status_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_re && !rx_done) |=> (status[5:3] == 3'b000));
endmodule

bind serial_xcvr sx_checker u_sx_checker (
    .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .rx_re(rx_re), .stat_re(stat_re),
    .txd(txd), .status(status), .rx_done(rx_done), .thr_q(u_tx.thr_q)
);

// File: tb/test_serial_xcvr.sv
`timescale 1ns/1ps
module test_serial_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic [1:0] tdiv;
    logic       mode_we = 1'b0, tx_we = 1'b0, rx_re = 1'b0, stat_re = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] rx_rdata, status;
    logic       txd;
    logic       loop_en = 1'b0, rxd_drv = 1'b1;
    logic       rxd;
    int         cyc = 0;
    int         n_chk = 0, n_fail = 0;

    localparam int BITCLK = 64;
    localparam int LIMIT  = 150000;
    localparam logic [13:0] VECS [6] = '{
        {6'h03, 8'hA5}, {6'h06, 8'h5B}, {6'h1D, 8'h2E},
        {6'h20, 8'hFF}, {6'h2F, 8'h80}, {6'h14, 8'h13}
    };

    assign rxd = loop_en ? txd : rxd_drv;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdiv   <= '0;
            tick16 <= 1'b0;
        end else begin
            tdiv   <= tdiv + 2'd1;
            tick16 <= (tdiv == 2'd2);
        end
    end

    serial_xcvr i_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata),
        .rx_re(rx_re), .rx_rdata(rx_rdata),
        .stat_re(stat_re), .status(status),
        .txd(txd), .rxd(rxd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [5:0] m);
        @(negedge clk); mode_wdata = m; mode_we = 1'b1;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_tx(input logic [7:0] d);
        @(negedge clk); tx_wdata = d; tx_we = 1'b1;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic rd_rx();
        @(negedge clk); rx_re = 1'b1;
        @(negedge clk); rx_re = 1'b0;
    endtask

    task automatic rd_stat();
        @(negedge clk); stat_re = 1'b1;
        @(negedge clk); stat_re = 1'b0;
    endtask

    function automatic int nbits_of(input logic [5:0] m);
        return 5 + int'(m[1:0]);
    endfunction

    function automatic int stop_ticks(input logic [5:0] m);
        case (m[5:4])
            2'd0:    return 16;
            2'd1:    return 24;
            default: return 32;
        endcase
    endfunction

    function automatic int flen(input logic [5:0] m);
        return nbits_of(m) + 2 + int'(m[2]);
    endfunction

    function automatic logic [7:0] dmask(input logic [5:0] m);
        return 8'hFF >> (8 - nbits_of(m));
    endfunction

    // start, data LSB first, optional parity, first stop level
    function automatic logic [11:0] frame_of(input logic [5:0] m, input logic [7:0] d);
        logic [11:0] f = '0;
        logic [7:0]  md = d & dmask(m);
        int k = 1;
        for (int i = 0; i < nbits_of(m); i++) begin f[k] = md[i]; k++; end
        if (m[2]) begin f[k] = (^md) ^ m[3]; k++; end
        f[k] = 1'b1;
        return f;
    endfunction

    task automatic wait_start(output int t);
        while (txd !== 1'b0) @(negedge clk);
        t = cyc;
    endtask

    task automatic grab_frame(input int t0, input logic [5:0] m, output logic [11:0] got);
        got = '0;
        for (int k = 0; k < flen(m); k++) begin
            wait_to(t0 + BITCLK / 2 + k * BITCLK);
            got[k] = txd;
        end
    endtask

    // drive a frame on rxd; last bit held for last_len clocks
    task automatic drive_frame(input logic [11:0] f, input int nb, input int last_len);
        for (int k = 0; k < nb; k++) begin
            rxd_drv = f[k];
            repeat ((k == nb - 1) ? last_len : BITCLK) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (cyc > LIMIT) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] got, exp;
        logic [5:0]  m;
        logic [7:0]  a, b;
        int t0, t1, len_clk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h05, "R1 status", status, 8'h05);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(rx_rdata == 8'h00, "R1 rx_rdata", rx_rdata, 0);

        // vector loop: loopback, two back-to-back bytes per mode
        loop_en = 1'b1;
        foreach (VECS[i]) begin
            m = VECS[i][13:8];
            a = VECS[i][7:0];
            b = ~a;
            wr_mode(m);
            rd_stat();
            wr_tx(a);
            wait_start(t0);
            chk(status[2] == 1'b0, "R6 busy not empty", status[2], 0);
            wr_tx(b);
            chk(status[0] == 1'b0, "R5 ready low when held", status[0], 0);
            grab_frame(t0, m, got);
            exp = frame_of(m, a);
            chk(got == exp, "R2 R3 frame A", got, exp);
            repeat (16) @(negedge clk);
            chk(status[1] == 1'b1, "R8 rx ready", status[1], 1);
            chk(rx_rdata == (a & dmask(m)), "R8 rx data A", rx_rdata, a & dmask(m));
            chk(status[5:3] == 3'b000, "R9 R10 no errors", status[5:3], 0);
            rd_rx();
            if (i == 0) chk(status[1] == 1'b0, "R8 read clears ready", status[1], 0);
            len_clk = ((1 + nbits_of(m) + int'(m[2])) * 16 + stop_ticks(m)) * 4;
            wait_to(t0 + len_clk - 1);
            chk(txd == 1'b1, "R4 stop still high", txd, 1);
            wait_to(t0 + len_clk);
            chk(txd == 1'b0, "R4 next start on time", txd, 0);
            t1 = t0 + len_clk;
            grab_frame(t1, m, got);
            exp = frame_of(m, b);
            chk(got == exp, "R2 R3 frame B", got, exp);
            repeat (16) @(negedge clk);
            chk(rx_rdata == (b & dmask(m)), "R8 rx data B", rx_rdata, b & dmask(m));
            rd_rx();
            while (status[2] !== 1'b1) @(negedge clk);
            chk(status[2:0] == 3'b101, "R6 drained", status[2:0], 3'b101);
        end

        // R5: write while full is dropped
        loop_en = 1'b0;
        wr_mode(6'h03);
        wr_tx(8'h11);
        wait_start(t0);
        wr_tx(8'h22);
        wr_tx(8'h33);
        grab_frame(t0 + 640, 6'h03, got);
        chk(got == frame_of(6'h03, 8'h22), "R5 held byte kept", got, frame_of(6'h03, 8'h22));
        while (status[2] !== 1'b1) @(negedge clk);
        repeat (700) @(negedge clk);
        chk(status[2] == 1'b1 && txd == 1'b1, "R5 dropped write sent nothing", {status[2], txd}, 2'b11);

        // R10: framing error
        got = frame_of(6'h03, 8'h55);
        got[9] = 1'b0;
        drive_frame(got, 10, 40);
        chk(status[5] == 1'b1, "R10 framing set", status[5], 1);
        chk(rx_rdata == 8'h55, "R10 data kept", rx_rdata, 8'h55);
        rd_stat();
        chk(status[5] == 1'b0, "R10 framing cleared", status[5], 0);
        rd_rx();

        // R9: parity error (7 bits even, parity bit inverted)
        wr_mode(6'h06);
        got = frame_of(6'h06, 8'h41);
        got[8] = ~got[8];
        drive_frame(got, 10, BITCLK);
        chk(status[3] == 1'b1 && status[5] == 1'b0, "R9 parity set", status[5:3], 3'b001);
        chk(rx_rdata == 8'h41, "R9 data", rx_rdata, 8'h41);
        rd_stat();
        chk(status[3] == 1'b0, "R9 parity cleared", status[3], 0);
        rd_rx();

        // R11: overrun
        wr_mode(6'h03);
        drive_frame(frame_of(6'h03, 8'h12), 10, BITCLK);
        drive_frame(frame_of(6'h03, 8'h34), 10, BITCLK);
        chk(status[4] == 1'b1, "R11 overrun set", status[4], 1);
        chk(rx_rdata == 8'h34, "R11 overwrite", rx_rdata, 8'h34);
        rd_stat();
        chk(status[4:3] == 2'b00 && status[1] == 1'b1, "R11 cleared ready kept", status, 8'h02);
        rd_rx();

        // R7: short glitch rejected, then valid frame accepted
        rxd_drv = 1'b0;
        repeat (20) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (800) @(negedge clk);
        chk(status[1] == 1'b0, "R7 glitch ignored", status[1], 0);
        drive_frame(frame_of(6'h03, 8'h6A), 10, BITCLK);
        chk(status[1] == 1'b1 && rx_rdata == 8'h6A, "R7 valid start", rx_rdata, 8'h6A);
        rd_rx();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule